// File: doc/BRIEF.md
# Programmable Product-Term Logic Block

This block is one configurable logic cell of a programmable-logic fabric. Eighteen routed signals enter a programmable AND plane that forms twenty data product terms and three control product terms. The data terms are grouped into four clusters of five, one cluster per output. Each output either ORs the first four terms of its own cluster on a short path, or ORs any chosen set of clusters (up to all twenty terms) and passes that sum through an XOR with a constant or with a product term. Each output is then taken straight through or from a register, and the four outputs go back to the routing so that any block, this one included, can use them.

The three control terms give a local register reset, an alternative register clock and an output-enable for the pin cells. All settings come from one static configuration image that is shifted in serially on a separate configuration clock while a load strobe is held high. Outside loading, the image does not change.

Top module: `plb_block`

## Requirements
- R1: While `cfg_load` is high, each rising edge of `cfg_clk` shifts `cfg_din` into the top of an 888-bit image and moves every bit one place down, so the first bit sent ends at bit 0. Term t occupies bits 37t..37t+36: [17:0] selects true inputs, [35:18] selects inverted inputs, [36] marks the term in use. Output k occupies bits 851+9k..851+9k+8: +0 wide mode, +1 registered, +2 term clock, +3..+6 cluster select (bit j for cluster j), +7 XOR constant, +8 XOR uses a term. Bit 887 enables the term reset. With `cfg_load` low, `cfg_clk` edges change nothing.
- R2: A product term not marked in use is 0. A term in use is the AND of its selected literals: 1 when none are selected, and 0 when an input is selected both true and inverted.
- R3: In the short mode, output k is the OR of terms 5k..5k+3; term 5k+4 and both XOR settings have no effect.
- R4: In wide mode, output k ORs all five terms of every selected cluster, up to all twenty terms. No selected cluster gives a sum of 0.
- R5: In wide mode, the sum is XORed with the constant bit. When the term option is set, it is instead XORed with term 5k+4, and that term is dropped from the sum of its own cluster.
- R6: A non-registered output follows its inputs combinationally, with no clock edge.
- R7: A registered output on the global clock shows the value its logic had just before a rising `clk` edge, from that edge until the next one.
- R8: With the term clock chosen, the register loads on rising edges of term 21 only, and `clk` has no effect on it.
- R9: `rst_n` low clears all four registers at once, without a clock edge, and holds them at 0 against clocked data.
- R10: With bit 887 set, term 20 high clears the registers at once and holds them cleared. With bit 887 clear, term 20 has no effect.
- R11: `oe_out` equals term 22.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global register clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_load | input | 1 | Shift enable for the configuration image |
| cfg_din | input | 1 | Serial configuration data |
| sig_in | input | 18 | Routed inputs to the AND plane |
| blk_out | output | 4 | Block outputs, returned to the routing |
| oe_out | output | 1 | Output-enable product term toward the pin cells |

## Verification
The hardest case to reach is a register clocked by a product term. The register must then ignore the free-running global clock and take its data only when a logic input makes term 21 rise. The stimulus ties term 21 to one input and the data term to another. It sets the data first, lets several global edges pass, and only then raises the clock input, so a capture on the wrong clock shows up as an early change. The same settle-then-act order is used for the local reset term. That term is raised between clock edges, so a cleared output before the next edge shows that the reset acts at once.

// File: rtl/plb_pkg.sv
package plb_pkg;
  parameter int N_IN      = 18;
  parameter int N_OUT     = 4;
  parameter int CL_TERMS  = 5;
  parameter int BYP_TERMS = 4;
  parameter int N_CTL     = 3;

  localparam int TERM_W   = 2 * N_IN + 1;
  localparam int N_DATA   = N_OUT * CL_TERMS;
  localparam int N_TERMS  = N_DATA + N_CTL;
  localparam int RST_T    = N_DATA;
  localparam int CLK_T    = N_DATA + 1;
  localparam int OE_T     = N_DATA + 2;
  localparam int OUT_W    = 5 + N_OUT;
  localparam int OUT_BASE = N_TERMS * TERM_W;
  localparam int GLB_BASE = OUT_BASE + N_OUT * OUT_W;
  localparam int CFG_W    = GLB_BASE + 1;

  // bit 0 = wide, bit 1 = registered, bit 2 = term clock, then cluster select,
  // XOR constant and XOR-from-term
  typedef struct packed {
    logic             xterm;
    logic             xconst;
    logic [N_OUT-1:0] alloc;
    logic             tclk;
    logic             regd;
    logic             wide;
  } out_cfg_t;

  function automatic logic term_eval(input logic [N_IN-1:0] x,
                                     input logic [TERM_W-1:0] c);
    logic [N_IN-1:0] tm;
    logic [N_IN-1:0] cm;
    tm = c[N_IN-1:0];
    cm = c[2*N_IN-1:N_IN];
    return c[TERM_W-1] & (&(x | ~tm)) & (&(~x | ~cm));
  endfunction

  function automatic out_cfg_t out_cfg(input logic [CFG_W-1:0] b, input int k);
    return out_cfg_t'(b[OUT_BASE + k*OUT_W +: OUT_W]);
  endfunction

  function automatic logic wide_sum(input logic [N_DATA-1:0] t,
                                    input out_cfg_t oc, input int k);
    logic s;
    s = 1'b0;
    for (int j = 0; j < N_OUT; j++) begin
      for (int m = 0; m < CL_TERMS; m++) begin
        if (oc.alloc[j] && !(oc.xterm && (j == k) && (m == CL_TERMS-1)))
          s = s | t[j*CL_TERMS + m];
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/plb_cfg_chain.sv
module plb_cfg_chain
  import plb_pkg::*;
(
  input  logic             cfg_clk,
  input  logic             cfg_load,
  input  logic             cfg_din,
  output logic [CFG_W-1:0] cfg_bits
);
  logic [CFG_W-1:0] sr;

  always_ff @(posedge cfg_clk) begin
    if (cfg_load) sr <= {cfg_din, sr[CFG_W-1:1]};
  end

  assign cfg_bits = sr;
endmodule

// File: rtl/plb_and_plane.sv
module plb_and_plane
  import plb_pkg::*;
(
  input  logic [N_IN-1:0]           sig_in,
  input  logic [N_TERMS*TERM_W-1:0] term_cfg,
  output logic [N_TERMS-1:0]        terms
);
  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    assign terms[t] = term_eval(sig_in, term_cfg[t*TERM_W +: TERM_W]);
  end
endmodule

// File: rtl/plb_out_cell.sv
module plb_out_cell
  import plb_pkg::*;
#(
  parameter int K = 0
) (
  input  logic              clk,
  input  logic              arst,
  input  logic              tclk_sig,
  input  logic [N_DATA-1:0] data_terms,
  input  out_cfg_t          oc,
  output logic              d_nxt,
  output logic              q,
  output logic              y
);
  localparam int BASE = K * CL_TERMS;
  localparam int XIDX = BASE + CL_TERMS - 1;

  logic byp_sum;
  logic wsum;
  logic xop;
  logic rclk;

  assign byp_sum = |data_terms[BASE +: BYP_TERMS];
  assign wsum    = wide_sum(data_terms, oc, K);
  assign xop     = oc.xterm ? data_terms[XIDX] : oc.xconst;
  assign d_nxt   = oc.wide ? (wsum ^ xop) : byp_sum;
  assign rclk    = oc.tclk ? tclk_sig : clk;

  always_ff @(posedge rclk or posedge arst) begin
    if (arst) q <= 1'b0;
    else      q <= d_nxt;
  end

  assign y = oc.regd ? q : d_nxt;
endmodule

// File: rtl/plb_block.sv
module plb_block
  import plb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_clk,
  input  logic            cfg_load,
  input  logic            cfg_din,
  input  logic [N_IN-1:0] sig_in,
  output logic [N_OUT-1:0] blk_out,
  output logic            oe_out
);
  logic [CFG_W-1:0]   cfg_bits;
  logic [N_TERMS-1:0] terms;
  logic [N_OUT-1:0]   reg_q;
  logic [N_OUT-1:0]   reg_d;
  logic               rst_hit;
  logic               arst;

  plb_cfg_chain u_cfg (
    .cfg_clk  (cfg_clk),
    .cfg_load (cfg_load),
    .cfg_din  (cfg_din),
    .cfg_bits (cfg_bits)
  );

  plb_and_plane u_plane (
    .sig_in   (sig_in),
    .term_cfg (cfg_bits[OUT_BASE-1:0]),
    .terms    (terms)
  );

  assign rst_hit = cfg_bits[GLB_BASE] & terms[RST_T];
  assign arst    = ~rst_n | rst_hit;
  assign oe_out  = terms[OE_T];

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    plb_out_cell #(.K(k)) u_cell (
      .clk        (clk),
      .arst       (arst),
      .tclk_sig   (terms[CLK_T]),
      .data_terms (terms[N_DATA-1:0]),
      .oc         (out_cfg(cfg_bits, k)),
      .d_nxt      (reg_d[k]),
      .q          (reg_q[k]),
      .y          (blk_out[k])
    );
  end
endmodule

// File: rtl/plb_block_chk.sv
module plb_block_chk
  import plb_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_clk,
  input logic               cfg_load,
  input logic [CFG_W-1:0]   cfg_bits,
  input logic [N_TERMS-1:0] terms,
  input logic [N_OUT-1:0]   blk_out,
  input logic [N_OUT-1:0]   reg_q,
  input logic [N_OUT-1:0]   reg_d,
  input logic               rst_hit
);
  assert_cfg_hold_R1: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !cfg_load |=> $stable(cfg_bits));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_rst_clear_R9: assert (reg_q == '0);
    end
  end

  assert_term_rst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |-> (reg_q == '0));

  for (genvar k = 0; k < N_OUT; k++) begin : g_k
    out_cfg_t oc;
    assign oc = out_cfg(cfg_bits, k);

    assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!oc.wide && !oc.regd) |-> (blk_out[k] == (|terms[k*CL_TERMS +: BYP_TERMS])));

    assert_reg_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_load && oc.regd && !oc.tclk && !rst_hit)
      |=> (cfg_load || rst_hit || (blk_out[k] == $past(reg_d[k]))));
  end
endmodule

bind plb_block plb_block_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_clk  (cfg_clk),
  .cfg_load (cfg_load),
  .cfg_bits (cfg_bits),
  .terms    (terms),
  .blk_out  (blk_out),
  .reg_q    (reg_q),
  .reg_d    (reg_d),
  .rst_hit  (rst_hit)
);

// File: tb/tb_plb_block.sv
module tb_plb_block;
  localparam int TW = 37;
  localparam int OB = 851;
  localparam int OW = 9;
  localparam int GB = 887;
  localparam int CW = 888;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        cfg_clk = 1'b0;
  logic        cfg_load = 1'b0;
  logic        cfg_din = 1'b0;
  logic [17:0] sig_in = '0;
  logic [3:0]  blk_out;
  logic        oe_out;

  logic [CW-1:0] img;
  int total = 0;
  int fails = 0;

  plb_block dut (
    .clk(clk), .rst_n(rst_n), .cfg_clk(cfg_clk), .cfg_load(cfg_load),
    .cfg_din(cfg_din), .sig_in(sig_in), .blk_out(blk_out), .oe_out(oe_out)
  );

  always #4 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic set_term(input int t, input logic [17:0] tm, input logic [17:0] cm);
    img[t*TW +: 18]      = tm;
    img[t*TW + 18 +: 18] = cm;
    img[t*TW + 36]       = 1'b1;
  endtask

  task automatic set_out(input int k, input logic wide, input logic regd,
                         input logic tclk, input logic [3:0] alloc,
                         input logic xc, input logic xt);
    int b;
    b = OB + k*OW;
    img[b]       = wide;
    img[b+1]     = regd;
    img[b+2]     = tclk;
    img[b+3 +: 4] = alloc;
    img[b+7]     = xc;
    img[b+8]     = xt;
  endtask

  task automatic load_img();
    @(negedge clk); #1;
    cfg_load = 1'b1;
    for (int i = 0; i < CW; i++) begin
      cfg_din = img[i];
      #2 cfg_clk = 1'b1;
      #2 cfg_clk = 1'b0;
    end
    cfg_load = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_reset();
    @(negedge clk); #1 rst_n = 1'b0;
    @(negedge clk); #1 rst_n = 1'b1;
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    #1 rst_n = 1'b0;
    img = '0;
    load_img();
    chk(blk_out[0], 1'b0, "R9 reset out0");
    chk(blk_out[3], 1'b0, "R9 reset out3");
    chk(oe_out, 1'b0, "R2 unused oe term is 0");
    @(negedge clk); #1 rst_n = 1'b1;
  endtask

  task automatic t_bypass();
    img = '0;
    set_term(0, 18'h00001, 18'h00002);   // in0 & ~in1
    set_term(1, 18'h00004, 18'h00000);   // in2
    set_term(2, 18'h00008, 18'h00008);   // in3 & ~in3
    set_term(4, 18'h00000, 18'h00000);   // empty -> 1, ignored in short path
    set_term(5, 18'h00000, 18'h00000);   // empty -> 1 for out1
    set_out(0, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b0);
    load_img();
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); sig_in = 18'(v); #1;
      chk(blk_out[0], ((v & 1) != 0 && (v & 2) == 0) || (v & 4) != 0,
          "R3 short path out0 (R2 literals, R6 comb)");
    end
    chk(blk_out[1], 1'b1, "R2 empty used term is 1");
    chk(blk_out[2], 1'b0, "R2 unused terms give 0");
  endtask

  task automatic t_wide();
    img = '0;
    set_term(0,  18'h00001, 18'h0);      // in0
    set_term(12, 18'h00020, 18'h0);      // in5
    set_term(14, 18'h000C0, 18'h0);      // in6 & in7
    set_term(19, 18'h00100, 18'h0);      // in8
    set_out(0, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b0);
    set_out(1, 1'b1, 1'b0, 1'b0, 4'b0101, 1'b1, 1'b0);
    set_out(2, 1'b1, 1'b0, 1'b0, 4'b0100, 1'b0, 1'b1);
    set_out(3, 1'b1, 1'b0, 1'b0, 4'b1111, 1'b0, 1'b0);
    load_img();
    for (int v = 0; v < 32; v++) begin
      logic a, e, f, g, h, p;
      a = v[0]; e = v[1]; f = v[2]; g = v[3]; h = v[4];
      p = f & g;
      @(negedge clk);
      sig_in = '0;
      sig_in[0] = a; sig_in[5] = e; sig_in[6] = f; sig_in[7] = g; sig_in[8] = h;
      #1;
      chk(blk_out[0], 1'b1, "R4 no cluster gives 0, R5 const 1");
      chk(blk_out[1], ~(a | e | p), "R4 two clusters R5 inverted by const");
      chk(blk_out[2], e ^ p, "R5 XOR with own term, term left out of sum");
      chk(blk_out[3], a | e | p | h, "R4 all twenty terms");
    end
  endtask

  task automatic t_cfg_ignore();
    @(negedge clk); #1;
    for (int i = 0; i < 50; i++) begin
      cfg_din = i[0];
      #2 cfg_clk = 1'b1;
      #2 cfg_clk = 1'b0;
    end
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      sig_in = '0; sig_in[5] = v[0]; sig_in[8] = v[1];
      #1;
      chk(blk_out[2], v[0], "R1 shift ignored without load, out2");
      chk(blk_out[3], v[0] | v[1], "R1 shift ignored without load, out3");
    end
  endtask

  task automatic t_registered();
    img = '0;
    set_term(0, 18'h00001, 18'h0);
    set_out(0, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b0);
    load_img();
    @(negedge clk); sig_in = '0;
    @(negedge clk); #1;
    chk(blk_out[0], 1'b0, "R7 registered low");
    sig_in[0] = 1'b1; #1;
    chk(blk_out[0], 1'b0, "R7 no change before edge");
    @(negedge clk); #1;
    chk(blk_out[0], 1'b1, "R7 captured at edge");
    sig_in[0] = 1'b0; #1;
    chk(blk_out[0], 1'b1, "R7 held until edge");
    @(negedge clk); #1;
    chk(blk_out[0], 1'b0, "R7 follows next edge");
  endtask

  task automatic t_async_rst();
    sig_in[0] = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    chk(blk_out[0], 1'b1, "R9 set before reset");
    #1 rst_n = 1'b0; #1;
    chk(blk_out[0], 1'b0, "R9 cleared without clock");
    @(negedge clk); @(negedge clk); #1;
    chk(blk_out[0], 1'b0, "R9 holds over data");
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(blk_out[0], 1'b1, "R9 released");
  endtask

  task automatic t_term_clk();
    img = '0;
    set_term(5,  18'h00002, 18'h0);      // in1
    set_term(21, 18'h20000, 18'h0);      // in17
    set_out(1, 1'b0, 1'b1, 1'b1, 4'b0000, 1'b0, 1'b0);
    load_img();
    sig_in = '0;
    pulse_reset();
    chk(blk_out[1], 1'b0, "R8 start low");
    sig_in[1] = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(blk_out[1], 1'b0, "R8 global clock ignored");
    sig_in[17] = 1'b1; #1;
    chk(blk_out[1], 1'b1, "R8 term clock rise captures");
    @(negedge clk); sig_in[1] = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(blk_out[1], 1'b1, "R8 held without term edge");
    sig_in[17] = 1'b0; #1;
    chk(blk_out[1], 1'b1, "R8 falling term edge ignored");
    sig_in[17] = 1'b1; #1;
    chk(blk_out[1], 1'b0, "R8 second rise captures");
  endtask

  task automatic t_term_rst(input logic en);
    img = '0;
    set_term(0,  18'h00001, 18'h0);      // in0
    set_term(20, 18'h10000, 18'h0);      // in16
    set_term(22, 18'h00200, 18'h00400);  // in9 & ~in10
    set_out(0, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b0);
    img[GB] = en;
    @(negedge clk); sig_in = '0;
    load_img();
    sig_in[0] = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    chk(blk_out[0], 1'b1, "R10 set before term reset");
    sig_in[16] = 1'b1; #1;
    if (en) begin
      chk(blk_out[0], 1'b0, "R10 term reset clears at once");
      @(negedge clk); @(negedge clk); #1;
      chk(blk_out[0], 1'b0, "R10 term reset holds");
      sig_in[16] = 1'b0;
      @(negedge clk); #1;
      chk(blk_out[0], 1'b1, "R10 release");
      for (int v = 0; v < 4; v++) begin
        @(negedge clk); sig_in[9] = v[0]; sig_in[10] = v[1]; #1;
        chk(oe_out, v[0] & ~v[1], "R11 output enable term");
      end
    end else begin
      @(negedge clk); @(negedge clk); #1;
      chk(blk_out[0], 1'b1, "R10 disabled term reset has no effect");
      sig_in[16] = 1'b0;
    end
  endtask

  initial begin
    #1_000_000;
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_bypass();
    t_wide();
    t_cfg_ignore();
    t_registered();
    t_async_rst();
    t_term_clk();
    t_term_rst(1'b1);
    t_term_rst(1'b0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule